// File: doc/BRIEF.md
# PWM Input Conditioner with Mode Select

This block cleans up a pair of PWM commands, one for the low-side switch and one for the high-side switch of a half-bridge, before they reach the gate channels. First, a width filter runs on each input. It rejects short spikes of either polarity and passes every accepted edge with a fixed delay. Second, a guard stage makes sure the two conditioned outputs are never high together. It enforces a minimum gap in which both outputs are low. When the incoming commands already leave enough room between them, the guard adds no delay.

A select input picks the operating mode, and it is captured only while reset is held. In direct mode the two commands are handled independently, except for the guard. In local mode the low-side input is ignored. The high-side output follows the high-side command, the low-side output is its complement, and a dead time is inserted at every transition. A synchronous enable from the fault logic pulls both outputs low on the next clock edge.

All timing values are counted in clock cycles and set by parameters:
- `GLITCH_CYC` is the minimum accepted width.
- `NOV_CYC` is the non-overlap gap in direct mode.
- `DEAD_CYC` is the dead time in local mode.

The inputs are assumed to be synchronous to `clk`.

Top module: `pwm_input_conditioner`

## Requirements
- R1: While `rstN` is low, both outputs are low whatever the inputs are. After release in direct mode with both inputs low, both outputs stay low.
- R2: A high or low pulse on either input that lasts fewer than `GLITCH_CYC` consecutive sampled cycles leaves the corresponding output unchanged.
- R3: In direct mode, when the guard does not intervene, an input level held for at least `GLITCH_CYC` sampled cycles reaches the output `GLITCH_CYC+1` clock edges after it is first sampled. This latency applies to rising and falling edges. A pulse exactly `GLITCH_CYC` cycles wide appears on the output as a pulse of the same width.
- R4: `pwmLoOut` and `pwmHiOut` are never high in the same cycle.
- R5: In direct mode, suppose an input rises at least `NOV_CYC` cycles after the other input fell. Its output then rises with the R3 latency and no added delay.
- R6: In both modes, the counting rule is the same. A rising output waits until the other output has been low for the required number of consecutive cycles, which is `NOV_CYC` in direct mode. It then rises on the edge that completes that count.
- R7: In direct mode, if both outputs would rise on the same edge, the high side rises and the low side stays low.
- R8: When `outEn` is low at a clock edge, both outputs are low after that edge. When `outEn` returns high, the outputs again follow the conditioned inputs under the guard.
- R9: In local mode, `pwmLoIn` has no effect on either output. `pwmHiOut` follows `pwmHiIn`, and `pwmLoOut` follows its inverse. The falling output switches with the R3 latency. The rising output follows after `DEAD_CYC` cycles in which both outputs are low.
- R10: `localSel` is sampled only while `rstN` is low: 1 selects local mode, 0 selects direct mode. Changing it after reset has no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low; also captures `localSel` |
| outEn | input | 1 | Output enable from fault logic; low forces both outputs low |
| localSel | input | 1 | Mode select: 1 = local (complementary from high-side input), 0 = direct |
| pwmLoIn | input | 1 | Low-side PWM command |
| pwmHiIn | input | 1 | High-side PWM command |
| pwmLoOut | output | 1 | Conditioned low-side gate command |
| pwmHiOut | output | 1 | Conditioned high-side gate command |

## Verification
Some properties are checked by assertions on every cycle:
- the two outputs are never high together;
- a disabled enable leaves both outputs low on the following cycle;
- every rising output edge is preceded by a low stretch of the other output at least as long as the gap that the captured mode requires.

Other behaviour can only be shown by the directed scenarios, because each depends on a particular input history:
- the exact latency of the width filter;
- rejection of narrow pulses of both polarities;
- the absence of extra delay for inputs that are already well separated;
- the tie rule;
- indifference to the low-side input in local mode;
- the fact that the mode select is ignored once reset has been released.

// File: rtl/pwm_cond_pkg.sv
package pwm_cond_pkg;

  // Strobes from the guard control to the output datapath
  typedef struct packed {
    logic permitLo;   // low-side output may rise on this edge
    logic permitHi;   // high-side output may rise on this edge
    logic modeLocal;  // captured mode: 1 = local, 0 = direct
  } guardStrobe_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pwm_glitch_filter.sv
// Minimum-width filter: the output takes a new level only after the input
// has shown that level for MIN_W consecutive sampled cycles.
module pwm_glitch_filter #(
  parameter int MIN_W = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic cleanOut
);
  localparam int CW = (MIN_W < 2) ? 1 : $clog2(MIN_W + 1);
  localparam logic [CW-1:0] LAST = CW'(MIN_W - 1);

  logic [CW-1:0] runCnt;
  logic level;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      level  <= 1'b0;
      runCnt <= '0;
    end else if (rawIn == level) begin
      runCnt <= '0;
    end else if (runCnt == LAST) begin
      level  <= rawIn;
      runCnt <= '0;
    end else begin
      runCnt <= runCnt + 1'b1;
    end
  end

  assign cleanOut = level;
endmodule

// File: rtl/pwm_guard_ctrl.sv
// Guard control: captures the mode at reset, counts how long each output
// has been low and issues permission strobes for rising edges.
module pwm_guard_ctrl
  import pwm_cond_pkg::*;
#(
  parameter int NOV_CYC  = 6,
  parameter int DEAD_CYC = 10
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         localSel,
  input  logic         outLo,
  input  logic         outHi,
  input  logic         wantHi,
  output guardStrobe_t strobe
);
  localparam int MAXT = maxOf(maxOf(NOV_CYC, DEAD_CYC), 1);
  localparam int CW   = $clog2(MAXT + 1);
  localparam logic [CW-1:0] CAP     = CW'(MAXT);
  localparam logic [CW-1:0] NOV_M1  = CW'((NOV_CYC  < 1) ? 0 : NOV_CYC - 1);
  localparam logic [CW-1:0] DEAD_M1 = CW'((DEAD_CYC < 1) ? 0 : DEAD_CYC - 1);

  logic modeLocal;
  logic [CW-1:0] thrM1;
  logic [1:0] outVec;
  logic [1:0] sideClear;
  logic [CW-1:0] lowCnt [2];

  // Mode latch: loads only while reset is held
  always_ff @(posedge clk) begin
    if (!rstN) modeLocal <= localSel;
  end

  assign thrM1  = modeLocal ? DEAD_M1 : NOV_M1;
  assign outVec = {outHi, outLo};

  // Index 0 = low side, 1 = high side
  for (genvar g = 0; g < 2; g++) begin : g_side
    always_ff @(posedge clk) begin
      if (!rstN)               lowCnt[g] <= CAP;
      else if (outVec[g])      lowCnt[g] <= '0;
      else if (lowCnt[g] != CAP) lowCnt[g] <= lowCnt[g] + 1'b1;
    end
    assign sideClear[g] = !outVec[g] && (lowCnt[g] >= thrM1);
  end

  always_comb begin
    strobe.modeLocal = modeLocal;
    strobe.permitHi  = sideClear[0];
    // High side wins a simultaneous rise
    strobe.permitLo  = sideClear[1] && !(wantHi && sideClear[0]);
  end
endmodule

// File: rtl/pwm_out_datapath.sv
// Datapath: input filters, mode-dependent source selection, output registers.
module pwm_out_datapath
  import pwm_cond_pkg::*;
#(
  parameter int GLITCH_CYC = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         outEn,
  input  logic         pwmLoIn,
  input  logic         pwmHiIn,
  input  guardStrobe_t strobe,
  output logic         outLo,
  output logic         outHi,
  output logic         wantHi
);
  logic [1:0] rawVec;
  logic [1:0] cleanVec;
  logic wantLo;

  assign rawVec = {pwmHiIn, pwmLoIn};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    pwm_glitch_filter #(.MIN_W(GLITCH_CYC)) u_filt (
      .clk     (clk),
      .rstN    (rstN),
      .rawIn   (rawVec[g]),
      .cleanOut(cleanVec[g])
    );
  end

  assign wantHi = cleanVec[1];
  assign wantLo = strobe.modeLocal ? !cleanVec[1] : cleanVec[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outLo <= 1'b0;
      outHi <= 1'b0;
    end else begin
      outLo <= outEn && wantLo && (outLo || strobe.permitLo);
      outHi <= outEn && wantHi && (outHi || strobe.permitHi);
    end
  end
endmodule

// File: rtl/pwm_input_conditioner.sv
module pwm_input_conditioner
  import pwm_cond_pkg::*;
#(
  parameter int GLITCH_CYC = 4,
  parameter int NOV_CYC    = 6,
  parameter int DEAD_CYC   = 10
) (
  input  logic clk,
  input  logic rstN,
  input  logic outEn,
  input  logic localSel,
  input  logic pwmLoIn,
  input  logic pwmHiIn,
  output logic pwmLoOut,
  output logic pwmHiOut
);
  guardStrobe_t strobe;
  logic wantHi;

  pwm_guard_ctrl #(.NOV_CYC(NOV_CYC), .DEAD_CYC(DEAD_CYC)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .localSel(localSel),
    .outLo   (pwmLoOut),
    .outHi   (pwmHiOut),
    .wantHi  (wantHi),
    .strobe  (strobe)
  );

  pwm_out_datapath #(.GLITCH_CYC(GLITCH_CYC)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .outEn  (outEn),
    .pwmLoIn(pwmLoIn),
    .pwmHiIn(pwmHiIn),
    .strobe (strobe),
    .outLo  (pwmLoOut),
    .outHi  (pwmHiOut),
    .wantHi (wantHi)
  );
endmodule

// File: rtl/pwm_input_conditioner_chk.sv
module pwm_input_conditioner_chk #(
  parameter int NOV_CYC  = 6,
  parameter int DEAD_CYC = 10
) (
  input logic clk,
  input logic rstN,
  input logic outEn,
  input logic localSel,
  input logic pwmLoOut,
  input logic pwmHiOut
);
  localparam int MAXT = (NOV_CYC > DEAD_CYC) ? NOV_CYC : DEAD_CYC;
  localparam int CW   = $clog2(MAXT + 2);
  localparam logic [CW-1:0] CAP = CW'(MAXT);

  logic modeChk;
  logic [CW-1:0] loLow, hiLow, thr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeChk <= localSel;
      loLow   <= CAP;
      hiLow   <= CAP;
    end else begin
      loLow <= pwmLoOut ? '0 : ((loLow == CAP) ? CAP : loLow + 1'b1);
      hiLow <= pwmHiOut ? '0 : ((hiLow == CAP) ? CAP : hiLow + 1'b1);
    end
  end

  assign thr = modeChk ? CW'(DEAD_CYC) : CW'(NOV_CYC);

  p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(pwmLoOut && pwmHiOut));

  p_enable_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    !outEn |=> (!pwmLoOut && !pwmHiOut));

  // R6 in direct mode, R9 dead time in local mode
  p_gap_hi_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwmHiOut) |-> (loLow >= thr));

  // R9 in local mode, R6 in direct mode
  p_gap_lo_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwmLoOut) |-> (hiLow >= thr));
endmodule

bind pwm_input_conditioner pwm_input_conditioner_chk #(
  .NOV_CYC (NOV_CYC),
  .DEAD_CYC(DEAD_CYC)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .outEn   (outEn),
  .localSel(localSel),
  .pwmLoOut(pwmLoOut),
  .pwmHiOut(pwmHiOut)
);

// File: tb/tb_pwm_input_conditioner.sv
module tb_pwm_input_conditioner;
  localparam int G = 4;
  localparam int N = 6;
  localparam int D = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic outEn = 1'b1;
  logic localSel = 1'b0;
  logic loIn = 1'b0;
  logic hiIn = 1'b0;
  logic loOut, hiOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwm_input_conditioner #(.GLITCH_CYC(G), .NOV_CYC(N), .DEAD_CYC(D)) dut (
    .clk(clk), .rstN(rstN), .outEn(outEn), .localSel(localSel),
    .pwmLoIn(loIn), .pwmHiIn(hiIn), .pwmLoOut(loOut), .pwmHiOut(hiOut)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic chkInt(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset(input logic mode);
    rstN = 1'b0; localSel = mode; loIn = 1'b0; hiIn = 1'b0; outEn = 1'b1;
    tick(3);
    rstN = 1'b1;
    tick(12);
  endtask

  task automatic testReset();
    rstN = 1'b0; localSel = 1'b0; loIn = 1'b1; hiIn = 1'b1;
    tick(4);
    chk("R1 lo in reset", loOut, 1'b0);
    chk("R1 hi in reset", hiOut, 1'b0);
    loIn = 1'b0; hiIn = 1'b0;
    tick(1);
    rstN = 1'b1;
    tick(3);
    chk("R1 lo after release", loOut, 1'b0);
    chk("R1 hi after release", hiOut, 1'b0);
    tick(12);
  endtask

  task automatic testGlitch();
    int seen = 0;
    hiIn = 1'b1; tick(G - 1); hiIn = 1'b0;
    for (int i = 0; i < 12; i++) begin tick(1); if (hiOut) seen++; end
    chkInt("R2 short high pulse hi", seen, 0);
    seen = 0;
    loIn = 1'b1; tick(G - 1); loIn = 1'b0;
    for (int i = 0; i < 12; i++) begin tick(1); if (loOut) seen++; end
    chkInt("R2 short high pulse lo", seen, 0);
    seen = 0;
    hiIn = 1'b1; tick(12);
    hiIn = 1'b0; tick(G - 1); hiIn = 1'b1;
    for (int i = 0; i < 12; i++) begin tick(1); if (!hiOut) seen++; end
    chkInt("R2 short low pulse hi", seen, 0);
    hiIn = 1'b0; tick(12);
  endtask

  task automatic testLatency();
    int seen = 0;
    hiIn = 1'b1;
    tick(G);     chk("R3 rise not yet", hiOut, 1'b0);
    tick(1);     chk("R3 rise on time", hiOut, 1'b1);
    hiIn = 1'b0;
    tick(G);     chk("R3 fall not yet", hiOut, 1'b1);
    tick(1);     chk("R3 fall on time", hiOut, 1'b0);
    tick(12);
    loIn = 1'b1; tick(G); loIn = 1'b0;
    for (int i = 0; i < 14; i++) begin tick(1); if (loOut) seen++; end
    chkInt("R3 exact-width pulse", seen, G);
    tick(6);
  endtask

  task automatic testTransparent();
    loIn = 1'b1; tick(12);
    loIn = 1'b0; tick(N);
    hiIn = 1'b1;
    tick(G);     chk("R5 separated not early", hiOut, 1'b0);
    tick(1);     chk("R5 separated no delay", hiOut, 1'b1);
    hiIn = 1'b0; tick(12);
  endtask

  task automatic testGapForce();
    loIn = 1'b1; tick(12);
    loIn = 1'b0; tick(N - 1);
    hiIn = 1'b1;
    tick(G + 1); chk("R6 short gap delayed", hiOut, 1'b0);
    tick(1);     chk("R6 short gap rises", hiOut, 1'b1);
    hiIn = 1'b0; tick(12);
    hiIn = 1'b1; tick(12);
    loIn = 1'b1; tick(10);
    chk("R6 lo held while hi high", loOut, 1'b0);
    hiIn = 1'b0;
    tick(G + N); chk("R6 lo waits full gap", loOut, 1'b0);
    tick(1);     chk("R6 lo rises after gap", loOut, 1'b1);
    chk("R6 hi low", hiOut, 1'b0);
    loIn = 1'b0; tick(12);
  endtask

  task automatic testTie();
    loIn = 1'b1; hiIn = 1'b1;
    tick(G + 1);
    chk("R7 tie hi wins", hiOut, 1'b1);
    chk("R7 tie lo held", loOut, 1'b0);
    tick(3);
    chk("R7 lo still held", loOut, 1'b0);
    loIn = 1'b0; hiIn = 1'b0; tick(12);
  endtask

  task automatic testEnable();
    hiIn = 1'b1; tick(12);
    outEn = 1'b0;
    tick(1); chk("R8 disable forces low", hiOut, 1'b0);
    tick(5); chk("R8 stays low", hiOut, 1'b0);
    outEn = 1'b1;
    tick(1); chk("R8 resumes", hiOut, 1'b1);
    hiIn = 1'b0; tick(12);
  endtask

  task automatic testLocal();
    int bad = 0;
    doReset(1'b1);
    chk("R9 idle lo high", loOut, 1'b1);
    chk("R9 idle hi low", hiOut, 1'b0);
    loIn = 1'b1;
    hiIn = 1'b1;
    tick(G);         chk("R9 lo before fall", loOut, 1'b1);
    tick(1);         chk("R9 lo falls", loOut, 1'b0);
    tick(D - 1);     chk("R9 hi waits dead time", hiOut, 1'b0);
    tick(1);         chk("R9 hi rises after dead time", hiOut, 1'b1);
    hiIn = 1'b0;
    tick(G);         chk("R9 hi before fall", hiOut, 1'b1);
    tick(1);         chk("R9 hi falls", hiOut, 1'b0);
    tick(D - 1);     chk("R9 lo waits dead time", loOut, 1'b0);
    tick(1);         chk("R9 lo rises after dead time", loOut, 1'b1);
    for (int i = 0; i < 16; i++) begin
      loIn = i[1];
      tick(1);
      if (!loOut || hiOut) bad++;
    end
    chkInt("R9 lo input ignored", bad, 0);
    loIn = 1'b0;
  endtask

  task automatic testModeLatch();
    localSel = 1'b0;
    tick(12);
    chk("R10 select change ignored", loOut, 1'b1);
    doReset(1'b0);
    chk("R10 direct after new reset", loOut, 1'b0);
  endtask

  initial begin
    testReset();
    testGlitch();
    testLatency();
    testTransparent();
    testGapForce();
    testTie();
    testEnable();
    testLocal();
    testModeLatch();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule